// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block takes one fast source clock and derives four divided clocks from it: three output banks (A, B and C, each fanned out to several identical lines) and one feedback clock meant to close an external phase-locked loop. Each output divides by an even ratio picked from a small table. One range bit doubles every ratio at once. Single-bit selects set the ratio of each bank, and a two-bit select sets the ratio of the feedback clock.

The divider source is normally the oscillator clock. A bypass control instead routes one of two reference clocks, chosen by a reference-select input, straight into the dividers for static test operation. An active-low clock-stop input parks the three banks low while the feedback clock keeps running. An active-low combined reset and output-enable input clears all dividers and marks every output as high-impedance. The high-impedance state is modelled by an enable bit that travels beside each output line.

Top module: `clkdiv_banks`

## Requirements
- R1: With rangeSel=0, banks A and B divide the source by 4 when their select is 0 and by 8 when it is 1.
- R2: With rangeSel=0, bank C divides the source by 8 when selC=0 and by 12 when selC=1.
- R3: With rangeSel=0, the feedback clock divides by 8, 16, 12 and 24 for selFb codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R4: With rangeSel=1, every ratio doubles: A and B give 8 or 16, C gives 16 or 24, and the feedback codes 2'b00, 2'b01, 2'b10 and 2'b11 give 16, 32, 24 and 48.
- R5: Every output has a 50% duty cycle. It is high for exactly half its ratio in source rising edges, then low for the other half.
- R6: After enRstN rises, every output goes high on the first source rising edge. From then on, every output rises on source edges 1, 1+N, 1+2N, and so on, where N is its ratio.
- R7: When pllOn=0, the dividers run from refClk0 if refSel=0 and from refClk1 if refSel=1, in place of vcoClk.
- R8: While stopN=0, every line of banks A, B and C stays low, and the feedback clock keeps its normal waveform.
- R9: stopN is sampled only on the source edge that would start a high phase of a bank. A bank never emits a shortened high pulse: a high phase that has begun always completes, and a suppressed one is wholly absent.
- R10: While enRstN=0, all enable outputs (oeA, oeB, oeC, oeFb) are 0 and all clock outputs are 0. Both take effect at once, without waiting for a clock edge, and the dividers hold in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vcoClk | input | 1 | Oscillator clock, the normal divider source |
| refClk0 | input | 1 | First reference clock |
| refClk1 | input | 1 | Second reference clock |
| refSel | input | 1 | Reference select: 0 picks refClk0, 1 picks refClk1 |
| pllOn | input | 1 | 1 selects vcoClk as source; 0 bypasses to the selected reference |
| rangeSel | input | 1 | 1 doubles every division ratio |
| selA | input | 1 | Bank A ratio select |
| selB | input | 1 | Bank B ratio select |
| selC | input | 1 | Bank C ratio select |
| selFb | input | 2 | Feedback ratio select |
| stopN | input | 1 | Active-low clock stop for banks A, B and C |
| enRstN | input | 1 | Active-low divider reset and output disable |
| qA | output | NUM_A | Bank A clock lines |
| qB | output | NUM_B | Bank B clock lines |
| qC | output | NUM_C | Bank C clock lines |
| qFb | output | 1 | Feedback clock |
| oeA | output | NUM_A | Bank A drive enables (0 = high-impedance) |
| oeB | output | NUM_B | Bank B drive enables |
| oeC | output | NUM_C | Bank C drive enables |
| oeFb | output | 1 | Feedback drive enable |

## Verification
On every source edge, the assertions check four things. A divider flips its raw clock only on its terminal count, and the count restarts at zero. A gated bank output rises and falls only together with its raw divider clock, so no runt pulse can escape the stop gate. The exact ratio for each select code, the alignment of all outputs to the first edge after reset, and the choice of divider source in bypass can only be shown by the bench's scenarios. Those scenarios compare the waveform at the ports against an edge-count model over windows of one hundred source edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Largest half-period in source edges (ratio 48 / 2)
  localparam int MAX_HALF = 24;
  localparam int CNT_W    = $clog2(MAX_HALF + 1) + 1;
  localparam int NUM_DIV  = 4;

  // Terminal counts (half-period minus one) handed from control to datapath
  typedef struct packed {
    logic [CNT_W-1:0] termA;
    logic [CNT_W-1:0] termB;
    logic [CNT_W-1:0] termC;
    logic [CNT_W-1:0] termFb;
  } divCfg_t;
endpackage

// File: rtl/clkdiv_srcmux.sv
module clkdiv_srcmux (
  input  logic vcoClk,
  input  logic refClk0,
  input  logic refClk1,
  input  logic refSel,
  input  logic pllOn,
  output logic srcClk
);
  logic refClk;
  assign refClk = refSel ? refClk1 : refClk0;
  assign srcClk = pllOn ? vcoClk : refClk;
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic       rangeSel,
  input  logic       selA,
  input  logic       selB,
  input  logic       selC,
  input  logic [1:0] selFb,
  output divCfg_t    cfg
);
  localparam logic [CNT_W-1:0] H2  = CNT_W'(2);
  localparam logic [CNT_W-1:0] H4  = CNT_W'(4);
  localparam logic [CNT_W-1:0] H6  = CNT_W'(6);
  localparam logic [CNT_W-1:0] H12 = CNT_W'(12);

  // Half-period at the low range, doubled by the range bit, minus one
  function automatic logic [CNT_W-1:0] toTerm(input logic [CNT_W-1:0] half,
                                               input logic rng);
    logic [CNT_W-1:0] scaled;
    scaled = rng ? (half << 1) : half;
    return scaled - 1'b1;
  endfunction

  logic [CNT_W-1:0] halfFb;

  always_comb begin
    unique case (selFb)
      2'b00:   halfFb = H4;
      2'b01:   halfFb = H4 << 1;
      2'b10:   halfFb = H6;
      default: halfFb = H12;
    endcase
  end

  always_comb begin
    cfg.termA  = toTerm(selA ? H4 : H2, rangeSel);
    cfg.termB  = toTerm(selB ? H4 : H2, rangeSel);
    cfg.termC  = toTerm(selC ? H6 : H4, rangeSel);
    cfg.termFb = toTerm(halfFb, rangeSel);
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] term,
  input  logic             stopN,
  output logic             qOut
);
  logic [CNT_W-1:0] cnt;
  logic             qRaw;
  logic             running;
  logic             wrap;

  // Count resets to all ones so the first edge after release wraps and rises
  assign wrap = (cnt >= term);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '1;
      qRaw <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      qRaw <= ~qRaw;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // Gate decision taken only on the edge that opens a high phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              running <= 1'b0;
    else if (wrap && !qRaw) running <= stopN;
  end

  assign qOut = qRaw & running;

  assert_toggle_at_term_R5: assert property (@(posedge clk) disable iff (!rstN)
    (qRaw != $past(qRaw)) |-> ($past(cnt) >= $past(term)));

  assert_restart_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (qRaw != $past(qRaw)) |-> (cnt == '0));

  assert_no_runt_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qOut) |-> $rose(qRaw));

  assert_no_runt_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qOut) |-> $fell(qRaw));
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int NUM_A = 5,
  parameter int NUM_B = 5,
  parameter int NUM_C = 4
) (
  input  logic             vcoClk,
  input  logic             refClk0,
  input  logic             refClk1,
  input  logic             refSel,
  input  logic             pllOn,
  input  logic             rangeSel,
  input  logic             selA,
  input  logic             selB,
  input  logic             selC,
  input  logic [1:0]       selFb,
  input  logic             stopN,
  input  logic             enRstN,
  output logic [NUM_A-1:0] qA,
  output logic [NUM_B-1:0] qB,
  output logic [NUM_C-1:0] qC,
  output logic             qFb,
  output logic [NUM_A-1:0] oeA,
  output logic [NUM_B-1:0] oeB,
  output logic [NUM_C-1:0] oeC,
  output logic             oeFb
);
  logic             srcClk;
  divCfg_t          cfg;
  logic [CNT_W-1:0] termArr [NUM_DIV];
  logic             stopArr [NUM_DIV];
  logic             qArr    [NUM_DIV];

  clkdiv_srcmux u_srcMux (
    .vcoClk (vcoClk), .refClk0(refClk0), .refClk1(refClk1),
    .refSel (refSel), .pllOn  (pllOn),   .srcClk (srcClk)
  );

  clkdiv_ctrl u_ctrl (
    .rangeSel(rangeSel), .selA(selA), .selB(selB), .selC(selC),
    .selFb   (selFb),    .cfg (cfg)
  );

  // Channel 3 is the feedback clock: its stop input is tied off
  assign termArr[0] = cfg.termA;
  assign termArr[1] = cfg.termB;
  assign termArr[2] = cfg.termC;
  assign termArr[3] = cfg.termFb;
  assign stopArr[0] = stopN;
  assign stopArr[1] = stopN;
  assign stopArr[2] = stopN;
  assign stopArr[3] = 1'b1;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_chan
    clkdiv_chan u_chan (
      .clk  (srcClk),
      .rstN (enRstN),
      .term (termArr[i]),
      .stopN(stopArr[i]),
      .qOut (qArr[i])
    );
  end

  assign qA   = {NUM_A{qArr[0]}};
  assign qB   = {NUM_B{qArr[1]}};
  assign qC   = {NUM_C{qArr[2]}};
  assign qFb  = qArr[3];
  assign oeA  = {NUM_A{enRstN}};
  assign oeB  = {NUM_B{enRstN}};
  assign oeC  = {NUM_C{enRstN}};
  assign oeFb = enRstN;
endmodule

// File: tb/clkdiv_banks_bench.sv
module clkdiv_banks_bench;
  localparam int NA = 5;
  localparam int NB = 5;
  localparam int NC = 4;
  localparam int VEC_N = 8;
  localparam int WIN = 100;

  // {rangeSel, selA, selB, selC, selFb[1:0]}
  localparam logic [5:0] VCFG [VEC_N] = '{
    6'b0_000_00, 6'b0_101_01, 6'b0_010_10, 6'b0_111_11,
    6'b1_000_00, 6'b1_101_01, 6'b1_010_10, 6'b1_111_11 };
  // expected ratios {A, B, C, Fb}
  localparam int VRAT [VEC_N][4] = '{
    '{4, 4, 8, 8},    '{8, 4, 12, 16},  '{4, 8, 8, 12},   '{8, 8, 12, 24},
    '{8, 8, 16, 16},  '{16, 8, 24, 32}, '{8, 16, 16, 24}, '{16, 16, 24, 48} };

  logic vcoClk = 0, refClk0 = 0, refClk1 = 0;
  logic refSel = 0, pllOn = 1, rangeSel = 0, selA = 0, selB = 0, selC = 0;
  logic [1:0] selFb = 2'b00;
  logic stopN = 1, enRstN = 0;
  logic [NA-1:0] qA, oeA;
  logic [NB-1:0] qB, oeB;
  logic [NC-1:0] qC, oeC;
  logic qFb, oeFb;
  logic benchSrc;
  int testCount = 0, failCount = 0;

  always #5  vcoClk  = ~vcoClk;
  always #13 refClk0 = ~refClk0;
  always #20 refClk1 = ~refClk1;
  assign benchSrc = pllOn ? vcoClk : (refSel ? refClk1 : refClk0);

  clkdiv_banks #(.NUM_A(NA), .NUM_B(NB), .NUM_C(NC)) u_clkdiv_banks (
    .vcoClk(vcoClk), .refClk0(refClk0), .refClk1(refClk1), .refSel(refSel),
    .pllOn(pllOn), .rangeSel(rangeSel), .selA(selA), .selB(selB), .selC(selC),
    .selFb(selFb), .stopN(stopN), .enRstN(enRstN),
    .qA(qA), .qB(qB), .qC(qC), .qFb(qFb),
    .oeA(oeA), .oeB(oeB), .oeC(oeC), .oeFb(oeFb));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expBit(input int k, input int r);
    return ((k - 1) % r) < (r / 2);
  endfunction

  // Reset with new controls applied; check outputs idle and disabled (R10)
  task automatic doReset(input logic [5:0] c, input logic pll, input logic rs);
    enRstN = 0;
    {rangeSel, selA, selB, selC, selFb} = c;
    pllOn = pll;
    refSel = rs;
    repeat (3) @(negedge benchSrc);
    chk((oeA == '0) && (oeB == '0) && (oeC == '0) && (oeFb == 1'b0), "R10",
        "enables during reset", int'({oeA, oeB, oeC, oeFb}), 0);
    chk((qA == '0) && (qB == '0) && (qC == '0) && (qFb == 1'b0), "R10",
        "clocks during reset", int'({qA, qB, qC, qFb}), 0);
    enRstN = 1;
  endtask

  // Walk WIN source edges from release and compare all outputs to the model
  task automatic runWindow(input int rA, input int rB, input int rC, input int rF,
                           input bit initStop, input int dropK, input int raiseK,
                           input string tag);
    int errA = 0, errB = 0, errC = 0, errF = 0;
    bit curStop = initStop;
    bit runA = 0, runB = 0, runC = 0;
    bit eA, eB, eC, eF;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge benchSrc);
      if (((k - 1) % rA) == 0) runA = curStop;
      if (((k - 1) % rB) == 0) runB = curStop;
      if (((k - 1) % rC) == 0) runC = curStop;
      eA = expBit(k, rA) & runA;
      eB = expBit(k, rB) & runB;
      eC = expBit(k, rC) & runC;
      eF = expBit(k, rF);
      if (qA !== {NA{eA}}) errA++;
      if (qB !== {NB{eB}}) errB++;
      if (qC !== {NC{eC}}) errC++;
      if (qFb !== eF) errF++;
      if (k == dropK)  begin stopN = 0; curStop = 0; end
      if (k == raiseK) begin stopN = 1; curStop = 1; end
    end
    chk(errA == 0, tag, "bank A mismatching edges", errA, 0);
    chk(errB == 0, tag, "bank B mismatching edges", errB, 0);
    chk(errC == 0, tag, "bank C mismatching edges", errC, 0);
    chk(errF == 0, tag, "feedback mismatching edges", errF, 0);
  endtask

  initial begin
    #2_000_000;
    failCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // Vector table: R1, R2, R3 at low range, R4 at high range; R5/R6 shape
    for (int v = 0; v < VEC_N; v++) begin
      stopN = 1;
      doReset(VCFG[v], 1'b1, 1'b0);
      runWindow(VRAT[v][0], VRAT[v][1], VRAT[v][2], VRAT[v][3], 1'b1, 0, 0,
                VCFG[v][5] ? "R4 R5 R6" : "R1 R2 R3 R5 R6");
    end

    // R7: bypass to refClk0, then to refClk1
    doReset(VCFG[0], 1'b0, 1'b0);
    runWindow(4, 4, 8, 8, 1'b1, 0, 0, "R7 refClk0");
    doReset(VCFG[7], 1'b0, 1'b1);
    runWindow(16, 16, 24, 48, 1'b1, 0, 0, "R7 refClk1");

    // R8: banks parked low from release, feedback keeps running
    stopN = 0;
    doReset(VCFG[1], 1'b1, 1'b0);
    runWindow(8, 4, 12, 16, 1'b0, 0, 0, "R8");

    // R9: stop dropped mid high phase, raised mid low phase
    stopN = 1;
    doReset(VCFG[0], 1'b1, 1'b0);
    runWindow(4, 4, 8, 8, 1'b1, 6, 14, "R9");

    // R10: asynchronous effect of reset while running
    @(negedge vcoClk);
    #2 enRstN = 0;
    #1;
    chk((oeA == '0) && (oeFb == 1'b0) && (qA == '0) && (qFb == 1'b0), "R10",
        "immediate disable mid-run", int'({oeA[0], oeFb, qA[0], qFb}), 0);
    doReset(VCFG[2], 1'b1, 1'b0);
    runWindow(4, 8, 8, 12, 1'b1, 0, 0, "R10 R6 restart");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule